// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block takes one transmit frame descriptor, already fetched from a descriptor ring, and turns it into a sequence of read requests, one for each buffer entry in the descriptor. The descriptor carries a count byte and up to twenty buffer entries. Each entry splits a 36-bit physical address into a 32-bit low word and a 4-bit high nibble, and packs that nibble next to a 12-bit length. The walker issues the entries in order over a valid/ready request port. It then signals that the frame is complete, or it stops and flags a format error.

A separate combinational path computes where a descriptor lives in memory. Each of sixteen queues has a ring of 256 descriptors of 128 bytes each. A ring's base is stored as physical address bits 35:8, because rings are 256-byte aligned. The fetch logic outside this block uses the resulting address. Memory bus access, data buffering and arbitration between queues are handled by neighbouring blocks.

Top module: `tx_sg_walker`

## Requirements
- R1: `descReady` is high exactly when no descriptor is in progress. A descriptor is taken on a cycle where `descValid` and `descReady` are both high, and `reqValid` is low while `descReady` is high.
- R2: Requests come out in entry order, starting with entry 0. Entry k occupies bits [48k+47:48k] of `descEntries`: bits 31:0 are address bits 31:0, bits 35:32 are address bits 35:32, and bits 47:36 are the length. `reqAddr` carries the 36-bit address and `reqLen` carries the length.
- R3: The number of active entries is bits 4:0 of `descCount`. Bits 7:5 have no effect.
- R4: An entry count above 20 raises `frameErr` in the cycle after acceptance, and no request is issued.
- R5: An entry with length 0, or with length above 4092, raises `frameErr` in place of its request. All entries before it have already been requested.
- R6: If an entry would bring the running length total of the frame above 8192, `frameErr` is raised in place of that request. A total of exactly 8192 is allowed.
- R7: `frameDone` pulses for one cycle, in the cycle after the last request is accepted. With a count of 0, it pulses in the cycle after acceptance. `descReady` returns high in the cycle after `frameDone` or `frameErr`.
- R8: While `reqValid` is high and `reqReady` is low, `reqValid`, `reqAddr` and `reqLen` hold their values into the next cycle.
- R9: `descAddr` equals (base of queue `queueSel` shifted left by 8) plus `ringIndex` times 128. Base q occupies bits [28q+27:28q] of `ringBaseFlat`.
- R10: `frameDone` and `frameErr` are never high together, each is a single-cycle pulse, and `reqValid` is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBaseFlat | input | 448 | Sixteen ring bases, address bits 35:8 each |
| queueSel | input | 4 | Queue whose ring address is computed |
| ringIndex | input | 8 | Descriptor slot within the ring |
| descAddr | output | 36 | Physical address of the selected descriptor |
| descValid | input | 1 | Descriptor presented |
| descReady | output | 1 | Walker idle, able to take a descriptor |
| descCount | input | 8 | Count byte; bits 4:0 give the entry count |
| descEntries | input | 960 | Twenty packed 48-bit buffer entries |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request accepted |
| reqAddr | output | 36 | Buffer physical address |
| reqLen | output | 12 | Buffer length in bytes |
| frameDone | output | 1 | Frame finished without error (pulse) |
| frameErr | output | 1 | Format error, walk aborted (pulse) |

## Verification
The bound checker checks the following on every cycle:
- requests hold steady under backpressure;
- the walker never offers a request while idle;
- an issued length is never zero and never above 4092;
- the completion and error pulses are single-cycle and mutually exclusive;
- the descriptor address stays 128-byte aligned.

Some behaviour only the bench's scenarios can show. This covers the exact order and content of the requests, the point at which an oversized frame total or a bad entry cuts a walk short, the 8192-byte boundary, the count field ignoring its upper bits, and the ring address arithmetic per queue. The bench checks these against a model of the descriptor format.

// File: rtl/tx_sg_pkg.sv
package tx_sg_pkg;
  localparam int ADDR_W  = 36;
  localparam int LO_W    = 32;
  localparam int HI_W    = 4;
  localparam int LEN_W   = 12;
  localparam int ENTRY_W = LO_W + HI_W + LEN_W;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic countBad;
    logic entryBad;
    logic atEnd;
  } dp_status_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} walk_state_t;
endpackage

// File: rtl/tx_sg_datapath.sv
module tx_sg_datapath
  import tx_sg_pkg::*;
#(
  parameter int MAX_TB    = 20,
  parameter int NUM_Q     = 16,
  parameter int BASE_W    = 28,
  parameter int RING_IW   = 8,
  parameter int DESC_LOG  = 7,
  parameter int MAX_BUF   = 4092,
  parameter int MAX_FRAME = 8192
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobe_t                strobe,
  output dp_status_t                  status,
  input  logic [NUM_Q*BASE_W-1:0]     ringBaseFlat,
  input  logic [$clog2(NUM_Q)-1:0]    queueSel,
  input  logic [RING_IW-1:0]          ringIndex,
  output logic [ADDR_W-1:0]           descAddr,
  input  logic [7:0]                  descCount,
  input  logic [MAX_TB*ENTRY_W-1:0]   descEntries,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic [LEN_W-1:0]            reqLen
);
  localparam int CNT_W   = 5;
  localparam int IDX_W   = $clog2(MAX_TB + 1);
  localparam int SUM_W   = $clog2(MAX_FRAME + (1 << LEN_W)) + 1;
  localparam int ALIGN_W = ADDR_W - BASE_W;
  localparam int OFF_W   = RING_IW + DESC_LOG;

  // ring base lookup and descriptor address
  logic [BASE_W-1:0] baseArr [NUM_Q];
  for (genvar q = 0; q < NUM_Q; q++) begin : g_base
    assign baseArr[q] = ringBaseFlat[q*BASE_W +: BASE_W];
  end
  assign descAddr = {baseArr[queueSel], {ALIGN_W{1'b0}}}
                  + {{(ADDR_W-OFF_W){1'b0}}, ringIndex, {DESC_LOG{1'b0}}};

  // descriptor storage
  logic [CNT_W-1:0]   cntQ;
  logic [IDX_W-1:0]   idxQ;
  logic [SUM_W-1:0]   sumQ;
  logic [ENTRY_W-1:0] entryArr [MAX_TB];
  logic [ENTRY_W-1:0] curEntry;

  for (genvar k = 0; k < MAX_TB; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)            entryArr[k] <= '0;
      else if (strobe.load) entryArr[k] <= descEntries[k*ENTRY_W +: ENTRY_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      idxQ <= '0;
      sumQ <= '0;
    end else if (strobe.load) begin
      cntQ <= descCount[CNT_W-1:0];
      idxQ <= '0;
      sumQ <= '0;
    end else if (strobe.advance) begin
      idxQ <= idxQ + 1'b1;
      sumQ <= sumQ + SUM_W'(reqLen);
    end
  end

  always_comb begin
    curEntry = '0;
    for (int k = 0; k < MAX_TB; k++)
      if (idxQ == IDX_W'(k)) curEntry = entryArr[k];
  end

  assign reqAddr = {curEntry[LO_W +: HI_W], curEntry[LO_W-1:0]};
  assign reqLen  = curEntry[LO_W+HI_W +: LEN_W];

  logic [SUM_W-1:0] nextSum;
  assign nextSum = sumQ + SUM_W'(reqLen);

  assign status.countBad = 32'(cntQ) > MAX_TB;
  assign status.atEnd    = IDX_W'(cntQ) == idxQ;
  assign status.entryBad = (reqLen == '0) || (32'(reqLen) > MAX_BUF)
                         || (32'(nextSum) > MAX_FRAME);
endmodule

// File: rtl/tx_sg_ctrl.sv
module tx_sg_ctrl
  import tx_sg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         descValid,
  output logic         descReady,
  input  logic         reqReady,
  output logic         reqValid,
  output logic         frameDone,
  output logic         frameErr,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe
);
  walk_state_t state, stateNext;
  logic running;

  assign running   = (state == ST_RUN);
  assign descReady = (state == ST_IDLE);
  assign frameErr  = running && (status.countBad || (!status.atEnd && status.entryBad));
  assign frameDone = running && !status.countBad && status.atEnd;
  assign reqValid  = running && !status.countBad && !status.atEnd && !status.entryBad;

  assign strobe.load    = descReady && descValid;
  assign strobe.advance = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    if (strobe.load)                 stateNext = ST_RUN;
    else if (frameDone || frameErr)  stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/tx_sg_walker.sv
module tx_sg_walker
  import tx_sg_pkg::*;
#(
  parameter int MAX_TB  = 20,
  parameter int NUM_Q   = 16,
  parameter int BASE_W  = 28,
  parameter int RING_IW = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_Q*BASE_W-1:0]   ringBaseFlat,
  input  logic [$clog2(NUM_Q)-1:0]  queueSel,
  input  logic [RING_IW-1:0]        ringIndex,
  output logic [ADDR_W-1:0]         descAddr,
  input  logic                      descValid,
  output logic                      descReady,
  input  logic [7:0]                descCount,
  input  logic [MAX_TB*ENTRY_W-1:0] descEntries,
  output logic                      reqValid,
  input  logic                      reqReady,
  output logic [ADDR_W-1:0]         reqAddr,
  output logic [LEN_W-1:0]          reqLen,
  output logic                      frameDone,
  output logic                      frameErr
);
  ctrl_strobe_t strobe;
  dp_status_t   status;

  tx_sg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
    .reqReady(reqReady), .reqValid(reqValid), .frameDone(frameDone),
    .frameErr(frameErr), .status(status), .strobe(strobe)
  );

  tx_sg_datapath #(
    .MAX_TB(MAX_TB), .NUM_Q(NUM_Q), .BASE_W(BASE_W), .RING_IW(RING_IW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .ringBaseFlat(ringBaseFlat), .queueSel(queueSel), .ringIndex(ringIndex),
    .descAddr(descAddr), .descCount(descCount), .descEntries(descEntries),
    .reqAddr(reqAddr), .reqLen(reqLen)
  );
endmodule

// File: rtl/tx_sg_checker.sv
module tx_sg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        descReady,
  input logic        reqValid,
  input logic        reqReady,
  input logic [35:0] reqAddr,
  input logic [11:0] reqLen,
  input logic        frameDone,
  input logic        frameErr,
  input logic [35:0] descAddr
);
  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> !reqValid);
  assert_len_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != 12'd0) && (reqLen <= 12'd4092));
  assert_back_to_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone || frameErr) |=> descReady);
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqLen)));
  assert_ring_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    descAddr[6:0] == 7'd0);
  assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(frameDone && frameErr) && !((frameDone || frameErr) && reqValid));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
endmodule

bind tx_sg_walker tx_sg_checker chk_i (
  .clk(clk), .rstN(rstN), .descReady(descReady), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
  .frameDone(frameDone), .frameErr(frameErr), .descAddr(descAddr)
);

// File: tb/tx_sg_walker_tb_top.sv
`timescale 1ns/1ps
module tx_sg_walker_tb_top;
  localparam int NTB = 20;
  localparam int NQ  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NQ*28-1:0]  ringBaseFlat = '0;
  logic [3:0]        queueSel = '0;
  logic [7:0]        ringIndex = '0;
  logic [35:0]       descAddr;
  logic              descValid = 1'b0;
  logic              descReady;
  logic [7:0]        descCount = '0;
  logic [NTB*48-1:0] descEntries = '0;
  logic              reqValid;
  logic              reqReady = 1'b1;
  logic [35:0]       reqAddr;
  logic [11:0]       reqLen;
  logic              frameDone, frameErr;

  tx_sg_walker dut_i (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit bpMode = 0;
  logic [7:0] lfsr = 8'hA5;

  // expected item: {kind[1:0], addr[35:0], len[11:0]}; kind 0=req 1=done 2=err
  logic [49:0] expQ [$];
  string curTag = "R2";

  logic [31:0] tLo [NTB];
  logic [3:0]  tHi [NTB];
  logic [11:0] tLen [NTB];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    reqReady <= bpMode ? lfsr[0] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && reqReady) begin
        if (expQ.size() == 0) check(0, curTag, "unexpected request", {reqAddr, reqLen}, 0);
        else begin
          logic [49:0] e;
          e = expQ.pop_front();
          check(e == {2'd0, reqAddr, reqLen}, curTag, "request", {2'd0, reqAddr, reqLen}, e);
        end
      end
      if (frameDone || frameErr) begin
        logic [1:0] k;
        k = frameDone ? 2'd1 : 2'd2;
        if (expQ.size() == 0) check(0, curTag, "unexpected end", k, 0);
        else begin
          logic [49:0] e;
          e = expQ.pop_front();
          check(e[49:48] == k, curTag, "end kind", k, e[49:48]);
        end
      end
    end
  end

  task automatic runDesc(input logic [7:0] cnt, input string tag);
    int n;
    int sum;
    bit stop;
    curTag = tag;
    n = int'(cnt[4:0]);
    sum = 0;
    stop = 0;
    for (int k = 0; k < NTB; k++)
      descEntries[k*48 +: 48] = {tLen[k], tHi[k], tLo[k]};
    if (n > 20) begin
      expQ.push_back({2'd2, 36'd0, 12'd0});
    end else begin
      for (int k = 0; k < n && !stop; k++) begin
        if (tLen[k] == 0 || tLen[k] > 4092 || sum + int'(tLen[k]) > 8192) begin
          expQ.push_back({2'd2, 36'd0, 12'd0});
          stop = 1;
        end else begin
          expQ.push_back({2'd0, tHi[k], tLo[k], tLen[k]});
          sum += int'(tLen[k]);
        end
      end
      if (!stop) expQ.push_back({2'd1, 36'd0, 12'd0});
    end
    descCount = cnt;
    @(negedge clk);
    while (!descReady) @(negedge clk);
    descValid = 1'b1;
    @(posedge clk); #1;
    descValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(descReady == 1'b1, "R7", "ready after end", descReady, 1);
  endtask

  task automatic fill(input int n, input logic [11:0] len);
    for (int k = 0; k < NTB; k++) begin
      tLo[k] = 32'h1000_0000 + 32'(k) * 32'h0001_0100;
      tHi[k] = 4'(k + 3);
      tLen[k] = (k < n) ? len : 12'd0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(descReady == 1'b1 && reqValid == 0 && frameDone == 0 && frameErr == 0,
          "R1", "reset state", {descReady, reqValid, frameDone, frameErr}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);

    fill(3, 12'd100); tLen[1] = 12'd333;
    runDesc(8'd3, "R2");
    fill(20, 12'd400);
    runDesc(8'd20, "R2");
    fill(2, 12'd50);
    runDesc(8'hE2, "R3");
    fill(20, 12'd10);
    runDesc(8'd21, "R4");
    runDesc(8'd31, "R4");
    fill(4, 12'd64); tLen[2] = 12'd0; tLen[3] = 12'd64;
    runDesc(8'd4, "R5");
    fill(2, 12'd100); tLen[0] = 12'd4093;
    runDesc(8'd2, "R5");
    fill(3, 12'd4092); tLen[2] = 12'd10;
    runDesc(8'd3, "R6");
    fill(3, 12'd4092); tLen[2] = 12'd8;
    runDesc(8'd3, "R6");
    fill(0, 12'd0);
    runDesc(8'd0, "R7");
    bpMode = 1;
    fill(12, 12'd300);
    runDesc(8'd12, "R8");
    fill(5, 12'd4092); tLen[1] = 12'd1; tLen[2] = 12'd5;
    runDesc(8'd5, "R6");
    bpMode = 0;

    // R9: ring address arithmetic
    for (int q = 0; q < NQ; q++)
      ringBaseFlat[q*28 +: 28] = 28'h0ABC000 + 28'(q) * 28'h0012345;
    for (int t = 0; t < 6; t++) begin
      logic [35:0] e;
      queueSel = 4'((t * 5) % 16);
      ringIndex = 8'((t * 97 + 255) % 256);
      e = {ringBaseFlat[int'(queueSel)*28 +: 28], 8'd0} + 36'(ringIndex) * 36'd128;
      #1;
      check(descAddr == e, "R9", "descriptor address", descAddr, e);
    end
    queueSel = 4'd15; ringIndex = 8'd255;
    ringBaseFlat[15*28 +: 28] = 28'hFFFFFFF;
    #1;
    check(descAddr == 36'hFFFFFFF00 + 36'd32640, "R9", "top slot address",
          descAddr, 36'hFFFFFFF00 + 36'd32640);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog %s actual=hung expected=finish", curTag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule